// File: doc/BRIEF.md
# Page write buffer and address counter for a serial byte store

This block sits behind a two-wire slave protocol engine and owns the byte storage of a small serial memory. It keeps the internal byte pointer and a staging buffer one page wide. The engine loads a start address, hands over data bytes one at a time, asks for read bytes, and reports the bus STOP. Written bytes collect in the staging buffer and only reach the array when a STOP closes the write command. The array is then updated in one timed write window, and the block reports itself busy for that whole window.

The array is organised as pages of 2^PAGE_W bytes. There are 2^PAGE_CNT_W pages. The upper pointer bits pick the page and the low PAGE_W bits pick the byte inside it. Writes move the pointer only inside the current page, so a long burst overwrites its own earlier bytes. Reads move the pointer through the whole array and roll over at the end. The production configuration is PAGE_W=5 and PAGE_CNT_W=8, with WR_CYCLES set to 5 ms of system clock. The defaults shown here are smaller so that the model elaborates cheaply.

Top module: `page_commit_store`

## Requirements
- R1: After reset, busy_o is 0, addr_o is 0, and every array byte reads back as 8'hFF.
- R2: An address load sets addr_o to addr_val_i. A read request with no new load returns the byte at the current addr_o.
- R3: Each accepted write byte goes to the buffer slot given by addr_o[PAGE_W-1:0]. The low PAGE_W bits of addr_o then count up modulo 2^PAGE_W, and the upper bits stay unchanged.
- R4: When a command writes one slot more than once, only the last byte written to that slot reaches the array.
- R5: Each accepted read moves addr_o up by one across page boundaries, and the all-ones address is followed by 0.
- R6: A STOP that ends a command holding at least one buffered byte sets busy_o on the next cycle. busy_o then stays high for exactly WR_CYCLES cycles. The array keeps its old contents until busy_o falls.
- R7: The commit changes only the slots written in the current command. Every other byte of the page keeps its earlier value.
- R8: A STOP after a command with zero data bytes starts no write window. A read request issued inside a write command also cancels it, so a later STOP starts nothing and the array stays unchanged.
- R9: While busy_o is high, address loads, write bytes, read requests and STOPs are ignored. No read response appears and addr_o does not change.
- R10: An accepted read request gives rd_valid_o high on the next cycle, with rd_data_o holding the array byte. rd_valid_o is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load_i | input | 1 | Start a command by loading the byte pointer |
| addr_val_i | input | PAGE_W+PAGE_CNT_W | Pointer value to load |
| wdata_valid_i | input | 1 | One data byte from the engine for the buffer |
| wdata_i | input | 8 | Data byte to buffer |
| rd_req_i | input | 1 | Request the byte at the pointer |
| stop_i | input | 1 | Bus STOP seen by the engine |
| busy_o | output | 1 | Timed write window in progress |
| addr_o | output | PAGE_W+PAGE_CNT_W | Current byte pointer |
| rd_valid_o | output | 1 | rd_data_o holds a read response |
| rd_data_o | output | 8 | Read response byte |

## Verification
The assertions check on every cycle the following pointer rules:
- a write step stays in the page;
- a read step rolls from the top address to 0;
- a qualifying STOP raises busy;
- an empty STOP does not;
- inputs have no effect while busy;
- each read request gets its response.

Some behaviours show only through the bench's read-back sweeps:
- the array contents: erased after reset, last-writer-wins inside a wrapped burst, untouched neighbour bytes;
- the exact length of the busy window;
- a cancelled command leaving storage unchanged.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef logic [7:0] byte_t;
  localparam byte_t ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/pcs_addr_ctr.sv
module pcs_addr_ctr #(
  parameter int PAGE_W     = 5,
  parameter int PAGE_CNT_W = 6,
  localparam int ADDR_W    = PAGE_W + PAGE_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              step_page_i,
  input  logic              step_array_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [PAGE_W-1:0] slot_inc;

  assign slot_inc = addr_q[PAGE_W-1:0] + PAGE_W'(1);

  always_comb begin
    addr_d = addr_q;
    if (load_i)            addr_d = load_val_i;
    else if (step_page_i)  addr_d = {addr_q[ADDR_W-1:PAGE_W], slot_inc};
    else if (step_array_i) addr_d = addr_q + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr_o = addr_q;

  // R3: a write step keeps the page and advances the slot modulo page size
  p_page_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_page_i && !load_i) |=>
      (addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W])) &&
      (addr_q[PAGE_W-1:0] == PAGE_W'($past(addr_q[PAGE_W-1:0]) + 1)));

  // R5: a read step at the top address rolls over to zero
  p_array_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_array_i && !load_i && !step_page_i && (&addr_q)) |=> (addr_q == '0));
endmodule

// File: rtl/pcs_page_buf.sv
module pcs_page_buf
  import pcs_pkg::*;
#(
  parameter int PAGE_W      = 5,
  localparam int PAGE_BYTES = 1 << PAGE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_i,
  input  logic [PAGE_W-1:0]          slot_i,
  input  byte_t                      data_i,
  input  logic                       clr_i,
  output logic [PAGE_BYTES-1:0][7:0] slots_o,
  output logic [PAGE_BYTES-1:0]      mask_o
);
  for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
    logic  hit;
    logic  used_q, used_d;
    byte_t data_q, data_d;

    assign hit = wr_i && (slot_i == PAGE_W'(s));

    always_comb begin
      used_d = used_q;
      data_d = data_q;
      if (clr_i) used_d = 1'b0;
      else if (hit) begin
        used_d = 1'b1;
        data_d = data_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        used_q <= 1'b0;
        data_q <= ERASED_BYTE;
      end else begin
        used_q <= used_d;
        if (hit && !clr_i) data_q <= data_d;
      end
    end

    assign slots_o[s] = data_q;
    assign mask_o[s]  = used_q;
  end
endmodule

// File: rtl/pcs_commit_timer.sv
module pcs_commit_timer #(
  parameter int WR_CYCLES = 500000,
  localparam int CNT_W    = $clog2(WR_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_q != '0)  cnt_d = cnt_q - CNT_W'(1);
    else if (start_i) cnt_d = CNT_W'(WR_CYCLES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1));

  // R6: an accepted start opens the busy window on the next cycle
  p_start_opens_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
endmodule

// File: rtl/page_commit_store.sv
module page_commit_store
  import pcs_pkg::*;
#(
  parameter int PAGE_W     = 5,
  parameter int PAGE_CNT_W = 6,
  parameter int WR_CYCLES  = 500000,
  localparam int ADDR_W     = PAGE_W + PAGE_CNT_W,
  localparam int PAGE_BYTES = 1 << PAGE_W,
  localparam int DEPTH      = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_val_i,
  input  logic              wdata_valid_i,
  input  logic [7:0]        wdata_i,
  input  logic              rd_req_i,
  input  logic              stop_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_valid_o,
  output logic [7:0]        rd_data_o
);
  logic idle, do_ld, do_wr, do_rd, do_stop, start_wr, commit;
  logic [ADDR_W-1:0] addr;
  logic [PAGE_BYTES-1:0][7:0] slots;
  logic [PAGE_BYTES-1:0] mask;
  logic  rd_valid_q, rd_valid_d;
  byte_t rd_data_q, rd_data_d;
  byte_t mem [DEPTH];

  // accepted requests, one per cycle, load wins over write over read over stop
  assign idle     = !busy_o;
  assign do_ld    = idle && addr_load_i;
  assign do_wr    = idle && !addr_load_i && wdata_valid_i;
  assign do_rd    = idle && !addr_load_i && !wdata_valid_i && rd_req_i;
  assign do_stop  = idle && !addr_load_i && !wdata_valid_i && !rd_req_i && stop_i;
  assign start_wr = do_stop && (mask != '0);

  pcs_addr_ctr #(.PAGE_W(PAGE_W), .PAGE_CNT_W(PAGE_CNT_W)) u_ctr (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (do_ld),
    .load_val_i   (addr_val_i),
    .step_page_i  (do_wr),
    .step_array_i (do_rd),
    .addr_o       (addr)
  );

  pcs_page_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (do_wr),
    .slot_i  (addr[PAGE_W-1:0]),
    .data_i  (wdata_i),
    .clr_i   (do_ld || do_rd || commit),
    .slots_o (slots),
    .mask_o  (mask)
  );

  pcs_commit_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_wr),
    .busy_o  (busy_o),
    .done_o  (commit)
  );

  // array: erased on reset, marked slots of the pointer's page land at window end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= ERASED_BYTE;
    end else if (commit) begin
      for (int s = 0; s < PAGE_BYTES; s++) begin
        if (mask[s]) mem[{addr[ADDR_W-1:PAGE_W], PAGE_W'(s)}] <= slots[s];
      end
    end
  end

  always_comb begin
    rd_valid_d = do_rd;
    rd_data_d  = rd_data_q;
    if (do_rd) rd_data_d = mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= ERASED_BYTE;
    end else begin
      rd_valid_q <= rd_valid_d;
      if (do_rd) rd_data_q <= rd_data_d;
    end
  end

  assign addr_o     = addr;
  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;

  // R8: a STOP with nothing buffered leaves the block idle
  p_empty_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (do_stop && (mask == '0)) |=> !busy_o);

  // R9: nothing offered during the busy window has a visible effect
  p_busy_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (!rd_valid_o && $stable(addr_o)));

  // R10: an accepted read is answered in the next cycle
  p_read_answer_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && !addr_load_i && !wdata_valid_i && !busy_o) |=> rd_valid_o);
endmodule

// File: tb/page_commit_store_test.sv
module page_commit_store_test;
  localparam int PW   = 5;
  localparam int PCW  = 3;
  localparam int AW   = PW + PCW;
  localparam int NB   = 1 << AW;
  localparam int WRC  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld = 1'b0, wv = 1'b0, rq = 1'b0, st = 1'b0;
  logic [AW-1:0] av = '0;
  logic [7:0] wd = '0;
  logic busy, rvalid;
  logic [AW-1:0] addr;
  logic [7:0] rdata;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [7:0] model [NB];

  always #5 clk = ~clk;

  page_commit_store #(.PAGE_W(PW), .PAGE_CNT_W(PCW), .WR_CYCLES(WRC)) uut (
    .clk(clk), .rst_n(rst_n), .addr_load_i(ld), .addr_val_i(av),
    .wdata_valid_i(wv), .wdata_i(wd), .rd_req_i(rq), .stop_i(st),
    .busy_o(busy), .addr_o(addr), .rd_valid_o(rvalid), .rd_data_o(rdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_load(input int a);
    @(negedge clk); ld = 1'b1; av = AW'(a);
    @(negedge clk); ld = 1'b0;
  endtask

  task automatic do_write(input int d);
    @(negedge clk); wv = 1'b1; wd = 8'(d);
    @(negedge clk); wv = 1'b0;
  endtask

  task automatic do_read(output logic v, output logic [7:0] d);
    @(negedge clk); rq = 1'b1;
    @(negedge clk); rq = 1'b0; v = rvalid; d = rdata;
  endtask

  task automatic do_stop();
    @(negedge clk); st = 1'b1;
    @(negedge clk); st = 1'b0;
  endtask

  // counts sampled busy cycles, starting at the current negedge
  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic sweep(input string req);
    logic v;
    logic [7:0] d;
    int errs = 0;
    do_load(0);
    for (int a = 0; a < NB; a++) begin
      do_read(v, d);
      if (!v || d != model[a]) begin
        errs++;
        chk(req, int'(d), int'(model[a]));
      end
    end
    if (errs == 0) chk(req, 1, 1);
    chk({req, " wrap to 0 (R5)"}, int'(addr), 0);
  endtask

  initial begin
    int n;
    logic v;
    logic [7:0] d;
    logic [AW-1:0] keep;
    for (int a = 0; a < NB; a++) model[a] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state and erased contents
    chk("R1 busy", int'(busy), 0);
    chk("R1 addr", int'(addr), 0);
    chk("R10 idle valid", int'(rvalid), 0);
    sweep("R1 erased sweep");

    // R3/R4/R6: 40-byte burst from page 1 slot 5 wraps inside page
    do_load(8'h25);
    chk("R2 load", int'(addr), 8'h25);
    for (int i = 0; i < 40; i++) begin
      do_write(i * 7 + 3);
      chk("R6 no busy before stop", int'(busy), 0);
    end
    chk("R3 pointer after burst", int'(addr), 8'h2D);
    do_stop();
    chk("R6 busy after stop", int'(busy), 1);
    wait_idle(n);
    chk("R6 window length", n, WRC);
    for (int i = 0; i < 40; i++) model[32 + ((5 + i) % 32)] = 8'(i * 7 + 3);
    sweep("R4 last-writer sweep");

    // R7: partial page write keeps neighbours
    do_load(8'h47);
    do_write(8'hA1); do_write(8'hB2); do_write(8'hC3);
    do_stop();
    wait_idle(n);
    chk("R7 window length", n, WRC);
    model[8'h47] = 8'hA1; model[8'h48] = 8'hB2; model[8'h49] = 8'hC3;
    sweep("R7 partial sweep");

    // R8: empty command and cancelled command
    do_load(8'h60);
    do_stop();
    chk("R8 empty stop", int'(busy), 0);
    do_load(8'h61);
    do_write(8'h5A);
    do_read(v, d);
    chk("R8 read returns old", int'(d), int'(model[8'h61]));
    do_stop();
    chk("R8 cancelled stop", int'(busy), 0);
    do_load(8'h61);
    do_read(v, d);
    chk("R8 byte kept", int'(d), int'(model[8'h61]));

    // R9: requests during busy have no effect
    do_load(8'hE0);
    do_write(8'h11);
    do_stop();
    keep = addr;
    do_read(v, d);
    chk("R9 no read while busy", int'(v), 0);
    chk("R9 addr after read", int'(addr), int'(keep));
    do_load(8'h03);
    chk("R9 addr after load", int'(addr), int'(keep));
    do_write(8'h77);
    chk("R9 addr after write", int'(addr), int'(keep));
    do_stop();
    wait_idle(n);
    model[8'hE0] = 8'h11;
    sweep("R9 sweep after busy");

    // R2/R5/R10: immediate reads and array roll-over
    do_load(8'h3E);
    do_read(v, d);
    chk("R10 valid", int'(v), 1);
    chk("R2 load then read", int'(d), int'(model[8'h3E]));
    do_read(v, d);
    chk("R2 immediate read", int'(d), int'(model[8'h3F]));
    do_read(v, d);
    chk("R5 cross page", int'(d), int'(model[8'h40]));
    do_load(NB - 1);
    do_read(v, d);
    chk("R5 top byte", int'(d), int'(model[NB - 1]));
    chk("R5 pointer roll", int'(addr), 0);
    do_read(v, d);
    chk("R5 byte after roll", int'(d), int'(model[0]));
    @(negedge clk);
    chk("R10 single pulse", int'(rvalid), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule